// File: doc/BRIEF.md
# Frame-Synchronized Burst Address Generator

This block turns a stream of burst-ready requests from an image capture chain into addressed memory writes. Every request carries one 32-byte burst (256 bits) of pixel data. The block writes each burst at the current frame-buffer address. It then moves the address forward by one burst and uses up one entry of a per-frame burst budget. With a 320 x 240 image at two bytes per pixel, one frame is 4800 bursts, or 150 kB.

A falling edge on the frame-sync input always puts the write pointer back at the programmed base address and reloads the burst budget, whatever state the block is in at that moment. Because of this, a burst that was lost or a burst that was spurious can only damage the frame it occurred in. Frames arrive about every 33 ms, which is 30 frames per second. When the budget reaches zero, the block flags frame completion. It then ignores all traffic until the next frame-sync edge.

The frame-sync input is taken to be synchronous to the clock already. The edge is seen in the first clock cycle in which the input is low after a cycle in which it was high.

Top module: `fsync_burst_agen`

## Requirements
- R1: After reset, `wr_valid` and `frame_done` are 0. The burst budget is empty, so requests made before the first frame-sync falling edge produce no write.
- R2: In the first cycle in which `vsync` is low after a high cycle, the write pointer is set to `cfg_base` and the budget is set to `cfg_count`. This happens whether the old budget was full, partly used or empty.
- R3: A request that is accepted in cycle N gives `wr_valid`=1 in cycle N+1. In that cycle `wr_addr` holds the pointer value for cycle N and `wr_data` holds the `req_data` of cycle N. A cycle with no accepted request gives `wr_valid`=0.
- R4: Within one frame, each accepted write goes to the previous write's address plus 32 (BURST_BYTES). This holds whether or not there are idle cycles between the requests.
- R5: `frame_done` is 1 in exactly the cycle in which the write that uses the last budget entry appears. It is 0 in every other cycle.
- R6: Once the budget is used up, requests produce no write until the next frame-sync falling edge.
- R7: A request in the same cycle as a frame-sync falling edge is written at the new `cfg_base`, using the new budget. The next write of that frame goes to `cfg_base` + 32.
- R8: Changes to `cfg_base` or `cfg_count` in any cycle other than a frame-sync falling edge have no effect on addresses or on the budget.
- R9: A rising edge of `vsync`, or `vsync` held at a steady level, does not reload the pointer or the budget.
- R10: If `cfg_count` is 0 when the edge is taken, every request in that frame is ignored and `frame_done` does not pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A burst is ready in this cycle |
| req_data | input | DATA_W (256) | Burst payload |
| vsync | input | 1 | Frame-sync level; its falling edge starts a frame |
| cfg_base | input | ADDR_W (32) | Frame-buffer base byte address, read only at the frame-sync edge |
| cfg_count | input | CNT_W (13) | Bursts per frame, read only at the frame-sync edge |
| wr_valid | output | 1 | Memory write strobe |
| wr_addr | output | ADDR_W (32) | Memory write byte address |
| wr_data | output | DATA_W (256) | Memory write data |
| frame_done | output | 1 | Pulses together with the last write of a frame |

## Verification
A request or a frame-sync edge takes effect in the cycle in which it is presented. Each write, together with any frame-done pulse, appears on the outputs exactly one clock later. The frame-sync edge itself adds no delay, so a request that coincides with the edge already uses the new base. The bench changes inputs on the falling clock edge and reads the outputs 1 ns after the next rising edge. Each read therefore sees the registered result of exactly one stimulus cycle, and every cycle in which the bench expects no write is checked for `wr_valid`=0 as well.

// File: rtl/fba_pkg.sv
// Shared constants and types for the frame-synchronized burst address generator.
// Assumes nothing beyond byte addressing of the frame buffer.
package fba_pkg;
    localparam int unsigned BURST_BYTES_DFLT = 32;
    localparam int unsigned FRAME_BURSTS_DFLT = 4800;

    // Frame budget state as seen by the write stage.
    typedef enum logic [0:0] {
        BUDGET_EMPTY = 1'b0,
        BUDGET_OPEN  = 1'b1
    } budget_e;
endpackage

// File: rtl/fba_edge_detect.sv
// Detects the falling edge of a frame-sync level that is already synchronous to clk.
// The edge pulse is combinational in the first low cycle, so a reload can act in that cycle.
module fba_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic fall_o
);
    logic level_q;

    // Keep last cycle's level; reset low so that no edge appears right after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level_i;
    end

    // Edge means high last cycle and low now.
    always_comb fall_o = level_q & ~level_i;
endmodule

// File: rtl/fba_iter_ctr.sv
// Per-frame burst budget. Reloads on the frame edge and grants requests while entries remain.
// Assumes a reload and a request in the same cycle are served from the reloaded value.
module fba_iter_ctr #(
    parameter int unsigned CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload_i,
    input  logic [CNT_W-1:0] reload_val_i,
    input  logic             req_i,
    output logic             accept_o,
    output logic             last_o,
    output fba_pkg::budget_e state_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] remain_q;
    logic [CNT_W-1:0] remain_eff;

    // Budget in force this cycle, taking a same-cycle reload into account.
    always_comb remain_eff = reload_i ? reload_val_i : remain_q;

    // Grant while the budget is open, and mark the grant that uses the last entry.
    always_comb begin
        state_o  = (remain_eff != '0) ? fba_pkg::BUDGET_OPEN : fba_pkg::BUDGET_EMPTY;
        accept_o = req_i && (state_o == fba_pkg::BUDGET_OPEN);
        last_o   = accept_o && (remain_eff == ONE);
    end

    // Hold the remaining-burst count; it starts empty after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        remain_q <= '0;
        else if (accept_o) remain_q <= remain_eff - ONE;
        else if (reload_i) remain_q <= reload_val_i;
    end
endmodule

// File: rtl/fba_addr_track.sv
// Write pointer. Rebases on the frame edge and steps by one burst after each granted write.
// Assumes byte addressing; the pointer wraps modulo 2**ADDR_W.
module fba_addr_track #(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned BURST_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rebase_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BURST_BYTES);

    logic [ADDR_W-1:0] ptr_q;

    // Address used this cycle: the new base if a rebase happens now.
    always_comb addr_o = rebase_i ? base_i : ptr_q;

    // Move past the written burst, or rebase on an edge that has no write.
    always_ff @(posedge clk) begin
        if (!rst_n)        ptr_q <= '0;
        else if (step_i)   ptr_q <= addr_o + STEP;
        else if (rebase_i) ptr_q <= base_i;
    end
endmodule

// File: rtl/fba_wr_stage.sv
// Output register for the memory write and the frame-done pulse.
// Assumes the granted address and data are stable in the grant cycle.
module fba_wr_stage #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic              last_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              valid_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o
);
    // Strobe and done pulse, one cycle after the grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            done_o  <= 1'b0;
        end else begin
            valid_o <= go_i;
            done_o  <= last_i;
        end
    end

    // Capture address and payload only when a write is granted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o <= '0;
            data_o <= '0;
        end else if (go_i) begin
            addr_o <= addr_i;
            data_o <= data_i;
        end
    end
endmodule

// File: rtl/fsync_burst_agen.sv
// Top level of the frame-synchronized burst address generator.
// Writes each granted capture burst at a pointer that steps by one burst. A falling edge of
// vsync forces the pointer back to cfg_base and the budget back to cfg_count.
// Assumes vsync is synchronous to clk and that cfg_* are stable around the edge cycle.
module fsync_burst_agen #(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned DATA_W      = 256,
    parameter int unsigned CNT_W       = 13,
    parameter int unsigned BURST_BYTES = fba_pkg::BURST_BYTES_DFLT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [DATA_W-1:0] req_data,
    input  logic              vsync,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [CNT_W-1:0]  cfg_count,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              frame_done
);
    logic              fs_edge;
    logic              grant;
    logic              grant_last;
    logic [ADDR_W-1:0] cur_addr;
    fba_pkg::budget_e  budget_state;

    fba_edge_detect u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (vsync),
        .fall_o  (fs_edge)
    );

    fba_iter_ctr #(.CNT_W(CNT_W)) u_iter (
        .clk          (clk),
        .rst_n        (rst_n),
        .reload_i     (fs_edge),
        .reload_val_i (cfg_count),
        .req_i        (req_valid),
        .accept_o     (grant),
        .last_o       (grant_last),
        .state_o      (budget_state)
    );

    fba_addr_track #(.ADDR_W(ADDR_W), .BURST_BYTES(BURST_BYTES)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .rebase_i (fs_edge),
        .base_i   (cfg_base),
        .step_i   (grant),
        .addr_o   (cur_addr)
    );

    fba_wr_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_i    (grant),
        .last_i  (grant_last),
        .addr_i  (cur_addr),
        .data_i  (req_data),
        .valid_o (wr_valid),
        .done_o  (frame_done),
        .addr_o  (wr_addr),
        .data_o  (wr_data)
    );
endmodule

// File: rtl/fsync_burst_agen_checker.sv
// Protocol checker for fsync_burst_agen, attached to it by the bind statement below.
module fsync_burst_agen_checker #(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned DATA_W      = 256,
    parameter int unsigned BURST_BYTES = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fs_edge,
    input logic              req_valid,
    input logic [DATA_W-1:0] req_data,
    input logic [ADDR_W-1:0] cfg_base,
    input logic              wr_valid,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              frame_done
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BURST_BYTES);

    // R3: a write needs a request one cycle before it, and carries that request's payload.
    a_r3_write_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> ($past(req_valid) && wr_data == $past(req_data)));

    // R2 and R7: a write granted in an edge cycle goes to the base sampled in that cycle.
    a_r7_edge_write_at_base: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && $past(fs_edge)) |-> (wr_addr == $past(cfg_base)));

    // R4: two successive writes with no edge between them are one burst apart.
    a_r4_step_one_burst: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && $past(wr_valid) && !$past(fs_edge)) |-> (wr_addr == $past(wr_addr) + STEP));

    // R5: the frame-done pulse only comes with a write.
    a_r5_done_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> wr_valid);

    // R6: right after frame-done, a write can only come from a fresh frame edge.
    a_r6_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && $past(frame_done)) |-> $past(fs_edge));
endmodule

bind fsync_burst_agen fsync_burst_agen_checker #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .BURST_BYTES (BURST_BYTES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fs_edge    (fs_edge),
    .req_valid  (req_valid),
    .req_data   (req_data),
    .cfg_base   (cfg_base),
    .wr_valid   (wr_valid),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .frame_done (frame_done)
);

// File: tb/fsync_burst_agen_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module fsync_burst_agen_bench;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 256;
    localparam int CNT_W  = 13;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [DATA_W-1:0] req_data = '0;
    logic              vsync = 1'b0;
    logic [ADDR_W-1:0] cfg_base = '0;
    logic [CNT_W-1:0]  cfg_count = '0;
    logic              wr_valid;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              frame_done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    fsync_burst_agen u_fsync_burst_agen (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_data(req_data),
        .vsync(vsync), .cfg_base(cfg_base), .cfg_count(cfg_count),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .frame_done(frame_done)
    );

    function automatic logic [DATA_W-1:0] pat(input int k);
        return {8{32'hA5C30000 + 32'(k)}};
    endfunction

    task automatic check(input string req, input string what, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One clock cycle of stimulus; afterwards the outputs show that cycle's result.
    task automatic tick(input logic rq, input logic [DATA_W-1:0] d, input logic vs);
        @(negedge clk);
        req_valid = rq;
        req_data  = d;
        vsync     = vs;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic expect_wr(input string req, input logic [ADDR_W-1:0] a,
                             input logic [DATA_W-1:0] d, input logic fd);
        check(req, "wr_valid", DATA_W'(wr_valid), DATA_W'(1'b1));
        check(req, "wr_addr", DATA_W'(wr_addr), DATA_W'(a));
        check(req, "wr_data", wr_data, d);
        check(req, "frame_done", DATA_W'(frame_done), DATA_W'(fd));
    endtask

    task automatic expect_none(input string req);
        check(req, "wr_valid", DATA_W'(wr_valid), DATA_W'(1'b0));
        check(req, "frame_done", DATA_W'(frame_done), DATA_W'(1'b0));
    endtask

    // Program cfg, then a high cycle and a low cycle so the edge is taken with no request.
    task automatic start_frame(input logic [ADDR_W-1:0] base, input logic [CNT_W-1:0] cnt);
        @(negedge clk);
        cfg_base  = base;
        cfg_count = cnt;
        tick(1'b0, '0, 1'b1);
        tick(1'b0, '0, 1'b0);
        expect_none("R2");
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        expect_none("R1");
        @(negedge clk);
        rst_n = 1'b1;
        tick(1'b1, pat(99), 1'b0);
        expect_none("R1");
        tick(1'b1, pat(98), 1'b0);
        expect_none("R1");
    endtask

    task automatic t_basic_frame;
        start_frame(32'h0000_1000, 13'd4);
        for (int i = 0; i < 4; i++) begin
            tick(1'b1, pat(i), 1'b0);
            expect_wr("R3", 32'h0000_1000 + 32'(i * 32), pat(i), (i == 3)); // R4, R5
        end
        tick(1'b0, '0, 1'b0);
        expect_none("R5");
    endtask

    task automatic t_after_done;
        tick(1'b1, pat(20), 1'b0);
        expect_none("R6");
        tick(1'b1, pat(21), 1'b0);
        expect_none("R6");
    endtask

    task automatic t_cfg_midframe;
        start_frame(32'h0000_2000, 13'd3);
        tick(1'b1, pat(30), 1'b0);
        expect_wr("R8", 32'h0000_2000, pat(30), 1'b0);
        @(negedge clk);
        cfg_base  = 32'h0000_9000;
        cfg_count = 13'd1;
        tick(1'b1, pat(31), 1'b0);
        expect_wr("R8", 32'h0000_2020, pat(31), 1'b0);
        tick(1'b0, '0, 1'b0);
        expect_none("R4");
        tick(1'b1, pat(32), 1'b0);
        expect_wr("R8", 32'h0000_2040, pat(32), 1'b1);
    endtask

    task automatic t_rise_and_resync;
        start_frame(32'h0000_3000, 13'd5);
        tick(1'b1, pat(40), 1'b0);
        expect_wr("R9", 32'h0000_3000, pat(40), 1'b0);
        tick(1'b1, pat(41), 1'b1);
        expect_wr("R9", 32'h0000_3020, pat(41), 1'b0);
        tick(1'b1, pat(42), 1'b1);
        expect_wr("R9", 32'h0000_3040, pat(42), 1'b0);
        @(negedge clk);
        cfg_base  = 32'h0000_4000;
        cfg_count = 13'd2;
        tick(1'b0, '0, 1'b0);
        expect_none("R2");
        tick(1'b1, pat(43), 1'b0);
        expect_wr("R2", 32'h0000_4000, pat(43), 1'b0);
        tick(1'b1, pat(44), 1'b0);
        expect_wr("R2", 32'h0000_4020, pat(44), 1'b1);
    endtask

    task automatic t_coincident;
        @(negedge clk);
        cfg_base  = 32'h0000_5000;
        cfg_count = 13'd3;
        tick(1'b0, '0, 1'b1);
        tick(1'b1, pat(50), 1'b0);
        expect_wr("R7", 32'h0000_5000, pat(50), 1'b0);
        tick(1'b1, pat(51), 1'b0);
        expect_wr("R7", 32'h0000_5020, pat(51), 1'b0);
        tick(1'b1, pat(52), 1'b0);
        expect_wr("R5", 32'h0000_5040, pat(52), 1'b1);
    endtask

    task automatic t_zero_count;
        start_frame(32'h0000_6000, 13'd0);
        tick(1'b1, pat(60), 1'b0);
        expect_none("R10");
        tick(1'b1, pat(61), 1'b0);
        expect_none("R10");
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #200000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic_frame();
        t_after_done();
        t_cfg_midframe();
        t_rise_and_resync();
        t_coincident();
        t_zero_count();
        finished = 1'b1;
        summary();
        $finish;
    end
endmodule